// File: doc/BRIEF.md
# Mode-Packed LCD Segment Memory

This block holds the on/off state of every element of a 40-column by 4-row liquid crystal panel. Each column drives one segment output and each row belongs to one backplane. A host delivers display bytes one per cycle, and the block writes each byte into the array in a packed order. The bits of a byte are taken most significant first. They fill the rows of one column before the pointer moves on to the next column. A group holds one, two, three or four bits, depending on the multiplex mode. Before a burst, a load strobe with a start column places the write pointer.

On the read side, a multiplex scanner gives the active backplane phase. The block returns the 40 segment bits of the matching row. A phase that the current mode does not use reads as zero. The block also reports, for each of the four backplane outputs, which backplane signal that output carries in the current mode. Pins that carry the same signal can then be tied together for extra drive.

Top module: `lcd_pack_ram`

## Requirements
- R1: While reset (rstN low) is applied, and after it is released, every stored bit is 0, the write pointer is at column 0 / row 0, and segRow is all zeros.
- R2: A stored 1 means the element is on and a 0 means it is off. segRow bit c is the stored bit at column c of the row selected by phase.
- R3: The mode encoding is 0 = static (1 row), 1 = 1:2 (2 rows), 2 = 1:3 (3 rows) and 3 = 1:4 (4 rows). On each cycle with byteValid high, byteData bits 7 down to 0 are written in that order. Each bit goes to the current (column, row) position. The row then increments, and after the last used row it returns to 0 and the column advances.
- R4: The row and column position persists between bytes, so a group can start in one byte and finish in the next (1:3 mode).
- R5: The column after 39 is column 0.
- R6: When loadPtr is high, the pointer is set to column startCol and row 0, and a byte accepted in the same cycle starts there. A startCol of 40 or more loads column 0.
- R7: Rows at or above the mode's row count are never written by a byte. When phase is at or above the row count, segRow is all zeros.
- R8: bpSource bits [2k+1:2k] give the backplane whose signal output k carries. The mapping is all 0 in static mode, 0,1,0,1 in 1:2 mode, 0,1,2,1 in 1:3 mode and 0,1,2,3 in 1:4 mode (for k = 0..3).
- R9: In a cycle with byteValid and loadPtr both low, no stored bit changes, whatever byteData holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Multiplex mode: 0 static, 1 1:2, 2 1:3, 3 1:4 |
| loadPtr | input | 1 | Load the write pointer from startCol, row 0 |
| startCol | input | 6 | Start column for a burst |
| byteValid | input | 1 | byteData holds a display byte this cycle |
| byteData | input | 8 | Display byte, consumed MSB first |
| phase | input | 2 | Active backplane phase (readout row) |
| segRow | output | 40 | Segment bits of the selected row, bit c = column c |
| bpSource | output | 8 | Per-output source backplane, 2 bits per output |

## Verification
A wrong row or column pointer shows up at the ports only when the affected cells are read. The error is visible in the cycle right after the misplaced byte, but only for the phase that covers the wrong cell. For that reason the reference compares segRow on every clock, and the stimulus moves phase across all rows. A pointer that drifts in 1:3 mode stays hidden for one byte and then shifts every group that follows. Wrap and load faults show up at columns 38, 39, 0 and 1 within two bytes.

// File: rtl/lcd_pack_pkg.sv
package lcd_pack_pkg;
  parameter int COLS   = 40;
  parameter int ROWS   = 4;
  parameter int BYTE_W = 8;
  localparam int COL_W = $clog2(COLS);
  localparam int ROW_W = $clog2(ROWS);
  localparam int ADV   = BYTE_W / ROWS;  // columns per byte in the widest mode

  typedef struct packed {
    logic                              wrEn;
    logic [BYTE_W-1:0][COL_W-1:0]      bitCol;
    logic [BYTE_W-1:0][ROW_W-1:0]      bitRow;
  } wrStrobe_t;
endpackage

// File: rtl/lcd_pack_ctrl.sv
module lcd_pack_ctrl
  import lcd_pack_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [ROW_W-1:0] mode,
  input  logic             loadPtr,
  input  logic [COL_W-1:0] startCol,
  input  logic             byteValid,
  output wrStrobe_t        strb
);
  logic [COL_W-1:0] colPtr, colNext;
  logic [ROW_W-1:0] rowPtr, rowNext;
  logic [ROW_W:0]   rowsUsed;

  assign rowsUsed = {1'b0, mode} + 1'b1;

  // Walk the pointer across every bit of the byte in one cycle
  always_comb begin : fillWalk
    logic [COL_W-1:0] c;
    logic [ROW_W:0]   r;
    if (loadPtr) begin
      c = (startCol < COL_W'(COLS)) ? startCol : '0;
      r = '0;
    end else begin
      c = colPtr;
      r = {1'b0, rowPtr};
      if (r >= rowsUsed) r = '0;
    end
    strb.wrEn = byteValid;
    for (int i = 0; i < BYTE_W; i++) begin
      strb.bitCol[i] = c;
      strb.bitRow[i] = r[ROW_W-1:0];
      if (byteValid) begin
        if (r + 1'b1 == rowsUsed) begin
          r = '0;
          c = (c == COL_W'(COLS-1)) ? '0 : c + 1'b1;
        end else begin
          r = r + 1'b1;
        end
      end
    end
    colNext = c;
    rowNext = r[ROW_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colPtr <= '0;
      rowPtr <= '0;
    end else if (loadPtr || byteValid) begin
      colPtr <= colNext;
      rowPtr <= rowNext;
    end
  end

  assert_col_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    colPtr < COL_W'(COLS));

  assert_row_after_byte_R3: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> {1'b0, rowPtr} < $past(rowsUsed));

  assert_quad_advance_R3: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !loadPtr && mode == ROW_W'(ROWS-1) && rowPtr == '0) |=>
      colPtr == (($past(colPtr) >= COL_W'(COLS-ADV)) ? $past(colPtr) - COL_W'(COLS-ADV)
                                                      : $past(colPtr) + COL_W'(ADV)));

  assert_load_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    (loadPtr && !byteValid) |=>
      (rowPtr == '0 && colPtr == (($past(startCol) < COL_W'(COLS)) ? $past(startCol) : '0)));
endmodule

// File: rtl/lcd_pack_dp.sv
module lcd_pack_dp
  import lcd_pack_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ROW_W-1:0]       mode,
  input  logic [BYTE_W-1:0]      byteData,
  input  wrStrobe_t              strb,
  input  logic [ROW_W-1:0]       phase,
  output logic [COLS-1:0]        segRow,
  output logic [ROWS*ROW_W-1:0]  bpSource
);
  logic [ROWS-1:0][COLS-1:0] cells;
  logic [ROW_W:0]            rowsUsed;

  assign rowsUsed = {1'b0, mode} + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cells <= '0;
    end else if (strb.wrEn) begin
      for (int i = 0; i < BYTE_W; i++)
        cells[strb.bitRow[i]][strb.bitCol[i]] <= byteData[BYTE_W-1-i];
    end
  end

  assign segRow = ({1'b0, phase} < rowsUsed) ? cells[phase] : '0;

  // Which backplane each output mirrors in the current mode
  always_comb begin
    for (int k = 0; k < ROWS; k++) begin
      int src;
      case (mode)
        2'd0:    src = 0;
        2'd1:    src = k % 2;
        2'd2:    src = (k == ROWS-1) ? 1 : k;
        default: src = k;
      endcase
      bpSource[k*ROW_W +: ROW_W] = ROW_W'(src);
    end
  end

  always_comb begin
    if (rstN && strb.wrEn) begin
      for (int i = 0; i < BYTE_W; i++)
        assert_no_unused_write_R7: assert ({1'b0, strb.bitRow[i]} < rowsUsed);
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn |=> $stable(cells));
endmodule

// File: rtl/lcd_pack_ram.sv
module lcd_pack_ram
  import lcd_pack_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ROW_W-1:0]      mode,
  input  logic                  loadPtr,
  input  logic [COL_W-1:0]      startCol,
  input  logic                  byteValid,
  input  logic [BYTE_W-1:0]     byteData,
  input  logic [ROW_W-1:0]      phase,
  output logic [COLS-1:0]       segRow,
  output logic [ROWS*ROW_W-1:0] bpSource
);
  wrStrobe_t strb;

  lcd_pack_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode), .loadPtr(loadPtr),
    .startCol(startCol), .byteValid(byteValid), .strb(strb)
  );

  lcd_pack_dp u_dp (
    .clk(clk), .rstN(rstN), .mode(mode), .byteData(byteData), .strb(strb),
    .phase(phase), .segRow(segRow), .bpSource(bpSource)
  );
endmodule

// File: tb/lcd_pack_ram_tb.sv
module lcd_pack_ram_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  mode = '0;
  logic        loadPtr = 1'b0;
  logic [5:0]  startCol = '0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic [1:0]  phase = '0;
  logic [39:0] segRow;
  logic [7:0]  bpSource;

  int    nTests = 0;
  int    nFail = 0;
  bit    armed = 1'b0;
  bit    done = 1'b0;
  string curTag = "R1";

  bit mBits [4][40];
  int mCol = 0;
  int mRow = 0;

  always #4 clk = ~clk;

  lcd_pack_ram u_dut (
    .clk(clk), .rstN(rstN), .mode(mode), .loadPtr(loadPtr), .startCol(startCol),
    .byteValid(byteValid), .byteData(byteData), .phase(phase),
    .segRow(segRow), .bpSource(bpSource)
  );

  // Behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    int rows, c, r;
    rows = int'(mode) + 1;
    if (!rstN) begin
      foreach (mBits[a, b]) mBits[a][b] = 1'b0;
      mCol = 0; mRow = 0;
    end else if (loadPtr || byteValid) begin
      if (loadPtr) begin
        c = (int'(startCol) < 40) ? int'(startCol) : 0;
        r = 0;
      end else begin
        c = mCol;
        r = (mRow >= rows) ? 0 : mRow;
      end
      if (byteValid) begin
        for (int i = 7; i >= 0; i--) begin
          mBits[r][c] = byteData[i];
          r++;
          if (r == rows) begin r = 0; c = (c + 1) % 40; end
        end
      end
      mCol = c; mRow = r;
    end
  end

  function automatic logic [39:0] expRow(input logic [1:0] m, input logic [1:0] p);
    logic [39:0] v = '0;
    if (int'(p) <= int'(m))
      for (int c = 0; c < 40; c++) v[c] = mBits[p][c];
    return v;
  endfunction

  function automatic logic [7:0] expSrc(input logic [1:0] m);
    case (m)
      2'd0: return 8'h00;
      2'd1: return 8'h44;
      2'd2: return 8'h64;
      default: return 8'hE4;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Full comparison against the reference on every falling edge
  always @(negedge clk) begin
    if (armed && !done) begin
      chk({curTag, " segRow"}, 64'(segRow), 64'(expRow(mode, phase)));
      chk({curTag, " bpSource"}, 64'(bpSource), 64'(expSrc(mode)));
    end
  end

  task automatic sendByte(input logic [7:0] d, input bit ld = 1'b0, input logic [5:0] sc = '0);
    @(negedge clk); #1;
    byteValid = 1'b1; byteData = d; loadPtr = ld; startCol = sc;
    @(negedge clk); #1;
    byteValid = 1'b0; loadPtr = 1'b0;
  endtask

  task automatic readRow(input logic [1:0] p);
    phase = p; #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    chk("R1 segRow in reset", 64'(segRow), 64'h0);
    @(negedge clk); #1 rstN = 1'b1;
    armed = 1'b1;
    @(negedge clk); #1;
    readRow(2'd0);
    chk("R1 segRow after reset", 64'(segRow), 64'h0);

    // R7: static writes touch row 0 only
    curTag = "R7";
    mode = 2'd0;
    sendByte(8'hFF, 1'b1, 6'd0);
    repeat (4) sendByte(8'hFF);
    readRow(2'd0);
    chk("R2 all on row0", 64'(segRow), 64'(40'hFF_FFFF_FFFF));
    readRow(2'd1);
    chk("R7 unused phase static", 64'(segRow), 64'h0);
    mode = 2'd3;
    for (int p = 1; p < 4; p++) begin
      readRow(2'(p));
      chk("R7 rows unwritten", 64'(segRow), 64'h0);
    end

    // R3: MSB-first placement in static mode
    curTag = "R3";
    mode = 2'd0;
    sendByte(8'hA5, 1'b1, 6'd0);
    readRow(2'd0);
    chk("R3 static MSB first", 64'(segRow[7:0]), 64'hA5);

    // R8: backplane sharing per mode
    curTag = "R8";
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m); #1;
      chk("R8 bpSource", 64'(bpSource), 64'(expSrc(2'(m))));
    end

    // R4: a triple group spans two bytes
    curTag = "R4";
    mode = 2'd2;
    sendByte(8'hFF, 1'b1, 6'd0);
    sendByte(8'h00);
    readRow(2'd0);
    chk("R4 row0 cols0-2", 64'(segRow[2:0]), 64'h7);
    readRow(2'd2);
    chk("R4 row2 split group", 64'(segRow[2:0]), 64'h3);
    readRow(2'd3);
    chk("R7 phase3 in 1:3", 64'(segRow), 64'h0);

    // R3: 1:2 mode with random data
    curTag = "R3";
    mode = 2'd1;
    sendByte(8'($urandom), 1'b1, 6'd5);
    for (int i = 0; i < 6; i++) sendByte(8'($urandom));
    readRow(2'd1);

    // R5: wrap from 39 to 0 in 1:4 mode
    curTag = "R5";
    mode = 2'd3;
    sendByte(8'hF0, 1'b1, 6'd38);
    sendByte(8'h0F);
    sendByte(8'h3C);
    readRow(2'd0);
    chk("R5 col38 on", 64'(segRow[38]), 64'h1);
    chk("R5 col39 off", 64'(segRow[39]), 64'h0);
    chk("R5 col0 off", 64'(segRow[0]), 64'h0);
    chk("R5 col1 on", 64'(segRow[1]), 64'h1);
    chk("R5 col2 row0", 64'(segRow[2]), 64'h0);
    readRow(2'd3);
    chk("R5 col2 row3", 64'(segRow[2]), 64'h1);

    // R6: out-of-range start column, and load-only strobe
    curTag = "R6";
    mode = 2'd0;
    sendByte(8'h80, 1'b1, 6'd50);
    readRow(2'd0);
    chk("R6 start>=40 gives col0", 64'(segRow[7:0]), 64'h01);
    @(negedge clk); #1 loadPtr = 1'b1; startCol = 6'd20;
    @(negedge clk); #1 loadPtr = 1'b0;
    sendByte(8'hFF);
    chk("R6 load then byte", 64'(segRow[27:20]), 64'hFF);

    // R9: idle cycles with data toggling
    curTag = "R9";
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1 byteData = 8'($urandom);
    end
    readRow(2'd0);
    chk("R9 idle keeps row0", 64'(segRow), 64'(expRow(2'd0, 2'd0)));

    // R2/R3: random traffic across modes and phases
    curTag = "R2";
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); #1;
      mode = 2'($urandom);
      phase = 2'($urandom);
      byteValid = ($urandom % 4) != 0;
      byteData = 8'($urandom);
      loadPtr = ($urandom % 16) == 0;
      startCol = 6'($urandom);
    end
    @(negedge clk); #1 byteValid = 1'b0; loadPtr = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule